// File: doc/BRIEF.md
# Doorbell and Interrupt Hub

This block joins two register ports that share one clock. The remote port can ring a 32-bit doorbell: each 1 in its write data sets the matching doorbell bit. The local port services the doorbell. It reads the pattern, then writes the same pattern back, which clears exactly those bits. Any set doorbell bit raises a doorbell summary line.

The same block aggregates interrupts for the local processor. An 8-bit status register collects event pulses on bits 0 to 6. Bit 7 tracks the doorbell summary one cycle late. An 8-bit enable register masks the status bits. The single level interrupt output is high while any status bit and its enable are both 1. It stays high until the local side clears the status bit or drops the enable.

Register offsets, on a 4-bit word address:
- Offset 0 is the doorbell. The remote port sets its bits and the local port clears them.
- Offset 1 is the status register, written 1-to-clear from the local port.
- Offset 2 is the enable register, read/write from the local port.

Top module: `doorbell_irq_hub`

## Requirements
- R1: A remote write to offset 0 sets every doorbell bit where the write data is 1. Bits written 0 are unchanged. Remote writes to any other offset have no effect.
- R2: A local write to offset 0 clears every doorbell bit where the write data is 1. Bits written 0 are unchanged.
- R3: If a remote set and a local clear hit the same doorbell bit in one cycle, the bit ends up set.
- R4: `db_irq` is the OR of all 32 doorbell bits, valid in the same cycle the register changes.
- R5: Status bit 7 equals the doorbell OR of the previous cycle. Writing 1 to bit 7 at offset 1 has no effect on it.
- R6: A pulse on `evt_set[i]`, for i from 0 to 6, sets status bit i at the next edge. `evt_set[7]` is ignored. A local write of 1 to bit i at offset 1 clears the bit. A set and a clear of the same bit in one cycle leave it set.
- R7: A local write to offset 2 loads the enable register from write data bits 7:0.
- R8: `irq_out` is high exactly when some status bit and its enable bit are both 1. It stays high until a status clear, a doorbell clear or an enable write removes every such pair.
- R9: Local read data is combinational:
  - offset 0 gives the doorbell;
  - offset 1 gives the status register, zero-extended;
  - offset 2 gives the enable register, zero-extended;
  - any other offset gives 0.
  Remote read data gives the doorbell at offset 0 and 0 elsewhere.
- R10: A synchronous active-high reset clears the doorbell, status and enable registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| rmt_addr | input | 4 | Remote port word address |
| rmt_we | input | 1 | Remote write strobe |
| rmt_wdata | input | 32 | Remote write data (1 bits set doorbell bits) |
| rmt_rdata | output | 32 | Remote read data |
| loc_addr | input | 4 | Local port word address |
| loc_we | input | 1 | Local write strobe |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local read data |
| evt_set | input | 8 | Event set pulses for status bits 0 to 6 (bit 7 unused) |
| db_irq | output | 1 | OR of all doorbell bits |
| irq_out | output | 1 | Level interrupt to the local processor |

## Verification
Assertions check the following on every cycle:
- the set and clear masks of the doorbell take effect, and bits outside both masks keep their value;
- a same-cycle set beats a clear;
- status bit 7 follows the delayed doorbell OR;
- event pulses land in the status register;
- enable writes load as written;
- an asserted interrupt holds while no clear or enable write happens.

Some behaviour only the bench scenarios can show. One is the full service sequence: read, write back, then watch both interrupt lines fall in the right cycles. Others are the read-back mapping, unmapped offsets reading zero, and remote writes to other offsets being dropped. The last is the state after a reset taken in the middle of activity.

// File: rtl/dbirq_pkg.sv
package dbirq_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int ST_W   = 8;
    localparam int DB_IDX = 7;

    typedef enum logic [ADDR_W-1:0] {
        REG_DOORBELL = 4'd0,
        REG_STATUS   = 4'd1,
        REG_ENABLE   = 4'd2
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    // Write data when the write hits the selected register, else all zero.
    function automatic logic [DATA_W-1:0] hit_mask(bus_wr_t w, reg_sel_e sel);
        return (w.we && (w.addr == sel)) ? w.data : '0;
    endfunction

    function automatic logic hit(bus_wr_t w, reg_sel_e sel);
        return w.we && (w.addr == sel);
    endfunction

endpackage

// File: rtl/dbirq_doorbell.sv
module dbirq_doorbell #(
    parameter int DB_W = dbirq_pkg::DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DB_W-1:0] set_mask,
    input  logic [DB_W-1:0] clr_mask,
    output logic [DB_W-1:0] db_q,
    output logic            db_any
);

    logic [DB_W-1:0] db_d;

    // Set applied after clear, so a ring in the same cycle survives.
    always_comb begin
        db_d = (db_q & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) db_q <= '0;
        else     db_q <= db_d;
    end

    assign db_any = |db_q;

    // R1 / R3: every requested set bit is present after the edge
    assert_set_lands_R1: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((db_q & $past(set_mask)) == $past(set_mask)));

    // R2: cleared bits with no competing set are gone after the edge
    assert_clear_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |=> ((db_q & $past(clr_mask & ~set_mask)) == '0));

    // R1 / R2: bits outside both masks keep their value
    assert_untouched_stable_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((db_q ^ $past(db_q)) & ~$past(set_mask | clr_mask)) == '0));

endmodule

// File: rtl/dbirq_status.sv
module dbirq_status #(
    parameter int ST_W   = dbirq_pkg::ST_W,
    parameter int DB_IDX = dbirq_pkg::DB_IDX
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] evt_set,
    input  logic            db_any,
    input  logic [ST_W-1:0] clr_mask,
    input  logic            en_we,
    input  logic [ST_W-1:0] en_wdata,
    output logic [ST_W-1:0] st_q,
    output logic [ST_W-1:0] en_q,
    output logic            irq
);

    for (genvar i = 0; i < ST_W; i++) begin : g_bit
        if (i == DB_IDX) begin : g_db
            // Mirrors the doorbell summary and ignores direct clears.
            always_ff @(posedge clk) begin
                if (rst) st_q[i] <= 1'b0;
                else     st_q[i] <= db_any;
            end

            // R5: delayed copy of the doorbell OR
            assert_db_mirror_R5: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (st_q[i] == $past(db_any)));
        end else begin : g_evt
            always_ff @(posedge clk) begin
                if (rst) st_q[i] <= 1'b0;
                else     st_q[i] <= evt_set[i] | (st_q[i] & ~clr_mask[i]);
            end

            // R6: an event pulse always lands, even against a clear
            assert_evt_sets_R6: assert property (@(posedge clk) disable iff (rst)
                evt_set[i] |=> st_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_we) en_q <= en_wdata;
    end

    assign irq = |(st_q & en_q);

    // R7: enable loads exactly what was written
    assert_en_load_R7: assert property (@(posedge clk) disable iff (rst)
        en_we |=> (en_q == $past(en_wdata)));

    // R8: no clear, no enable write and the doorbell still set keep irq high
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && (clr_mask == '0) && !en_we && db_any) |=> irq);

endmodule

// File: rtl/dbirq_rdmux.sv
module dbirq_rdmux #(
    parameter int ADDR_W = dbirq_pkg::ADDR_W,
    parameter int DATA_W = dbirq_pkg::DATA_W,
    parameter int ST_W   = dbirq_pkg::ST_W
) (
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [ADDR_W-1:0] rmt_addr,
    input  logic [DATA_W-1:0] db_q,
    input  logic [ST_W-1:0]   st_q,
    input  logic [ST_W-1:0]   en_q,
    output logic [DATA_W-1:0] loc_rdata,
    output logic [DATA_W-1:0] rmt_rdata
);
    import dbirq_pkg::*;

    localparam int PAD_W = DATA_W - ST_W;

    always_comb begin
        unique case (loc_addr)
            REG_DOORBELL: loc_rdata = db_q;
            REG_STATUS:   loc_rdata = {{PAD_W{1'b0}}, st_q};
            REG_ENABLE:   loc_rdata = {{PAD_W{1'b0}}, en_q};
            default:      loc_rdata = '0;
        endcase
    end

    assign rmt_rdata = (rmt_addr == REG_DOORBELL) ? db_q : '0;

endmodule

// File: rtl/doorbell_irq_hub.sv
module doorbell_irq_hub
    import dbirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rmt_addr,
    input  logic              rmt_we,
    input  logic [DATA_W-1:0] rmt_wdata,
    output logic [DATA_W-1:0] rmt_rdata,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic              loc_we,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] loc_rdata,
    input  logic [ST_W-1:0]   evt_set,
    output logic              db_irq,
    output logic              irq_out
);

    bus_wr_t          rmt_wr, loc_wr;
    logic [DATA_W-1:0] db_set, db_clr, db_q;
    logic [DATA_W-1:0] loc_st_word, loc_en_word;
    logic [ST_W-1:0]   st_clr, st_q, en_q;
    logic              db_any;

    assign rmt_wr = '{we: rmt_we, addr: rmt_addr, data: rmt_wdata};
    assign loc_wr = '{we: loc_we, addr: loc_addr, data: loc_wdata};

    assign db_set      = hit_mask(rmt_wr, REG_DOORBELL);
    assign db_clr      = hit_mask(loc_wr, REG_DOORBELL);
    assign loc_st_word = hit_mask(loc_wr, REG_STATUS);
    assign loc_en_word = loc_wr.data;
    assign st_clr      = loc_st_word[ST_W-1:0];

    dbirq_doorbell #(.DB_W(DATA_W)) u_doorbell (
        .clk      (clk),
        .rst      (rst),
        .set_mask (db_set),
        .clr_mask (db_clr),
        .db_q     (db_q),
        .db_any   (db_any)
    );

    dbirq_status #(.ST_W(ST_W), .DB_IDX(DB_IDX)) u_status (
        .clk      (clk),
        .rst      (rst),
        .evt_set  (evt_set),
        .db_any   (db_any),
        .clr_mask (st_clr),
        .en_we    (hit(loc_wr, REG_ENABLE)),
        .en_wdata (loc_en_word[ST_W-1:0]),
        .st_q     (st_q),
        .en_q     (en_q),
        .irq      (irq_out)
    );

    dbirq_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ST_W(ST_W)) u_rdmux (
        .loc_addr  (loc_addr),
        .rmt_addr  (rmt_addr),
        .db_q      (db_q),
        .st_q      (st_q),
        .en_q      (en_q),
        .loc_rdata (loc_rdata),
        .rmt_rdata (rmt_rdata)
    );

    assign db_irq = db_any;

    // R10: the cycle after reset everything reads as idle
    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (!db_irq && !irq_out && db_q == '0));

endmodule

// File: tb/doorbell_irq_hub_bench.sv
`timescale 1ns/100ps
module doorbell_irq_hub_bench;

    localparam real PERIOD = 5.0;
    localparam int  WD_CYC = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rmt_addr = '0, loc_addr = '0;
    logic        rmt_we = 1'b0, loc_we = 1'b0;
    logic [31:0] rmt_wdata = '0, loc_wdata = '0;
    logic [31:0] rmt_rdata, loc_rdata;
    logic [7:0]  evt_set = '0;
    logic        db_irq, irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    // Expected state, updated only by the bench functions below.
    logic [31:0] m_db = '0;
    logic [7:0]  m_st = '0, m_en = '0;

    always #(PERIOD/2) clk = ~clk;

    doorbell_irq_hub u_doorbell_irq_hub (
        .clk(clk), .rst(rst),
        .rmt_addr(rmt_addr), .rmt_we(rmt_we), .rmt_wdata(rmt_wdata), .rmt_rdata(rmt_rdata),
        .loc_addr(loc_addr), .loc_we(loc_we), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .evt_set(evt_set), .db_irq(db_irq), .irq_out(irq_out)
    );

    function automatic logic [31:0] nx_db(logic [31:0] db, logic rw, logic [3:0] ra,
                                          logic [31:0] rd, logic lw, logic [3:0] la,
                                          logic [31:0] ld);
        logic [31:0] s, c;
        s = (rw && ra == 4'd0) ? rd : 32'd0;
        c = (lw && la == 4'd0) ? ld : 32'd0;
        return (db & ~c) | s;
    endfunction

    function automatic logic [7:0] nx_st(logic [7:0] st, logic [31:0] db, logic [7:0] ev,
                                         logic lw, logic [3:0] la, logic [31:0] ld);
        logic [7:0] r, c;
        c = (lw && la == 4'd1) ? ld[7:0] : 8'd0;
        r = (st & ~c) | (ev & 8'h7F);
        r[7] = (db != 32'd0);
        return r;
    endfunction

    function automatic logic [7:0] nx_en(logic [7:0] en, logic lw, logic [3:0] la,
                                         logic [31:0] ld);
        return (lw && la == 4'd2) ? ld[7:0] : en;
    endfunction

    function automatic logic [31:0] exp_rd(logic [3:0] a);
        case (a)
            4'd0:    return m_db;
            4'd1:    return {24'd0, m_st};
            4'd2:    return {24'd0, m_en};
            default: return 32'd0;
        endcase
    endfunction

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, model the edge, then read back.
    task automatic step(logic rw, logic [3:0] ra, logic [31:0] rd,
                        logic lw, logic [3:0] la, logic [31:0] ld,
                        logic [7:0] ev, logic [3:0] rda, string tag);
        logic [31:0] ndb;
        logic [7:0]  nst, nen;
        @(negedge clk);
        rmt_we = rw; rmt_addr = ra; rmt_wdata = rd;
        loc_we = lw; loc_addr = la; loc_wdata = ld;
        evt_set = ev;
        ndb = nx_db(m_db, rw, ra, rd, lw, la, ld);
        nst = nx_st(m_st, m_db, ev, lw, la, ld);
        nen = nx_en(m_en, lw, la, ld);
        @(posedge clk);
        #1;
        m_db = ndb; m_st = nst; m_en = nen;
        rmt_we = 1'b0; loc_we = 1'b0; evt_set = '0;
        rmt_addr = 4'd0; loc_addr = rda;
        #0.5;
        cmp({tag, " rmt_rdata"}, rmt_rdata, m_db);
        cmp({tag, " loc_rdata"}, loc_rdata, exp_rd(rda));
        cmp("R4 db_irq", {31'd0, db_irq}, {31'd0, m_db != 32'd0});
        cmp("R8 irq_out", {31'd0, irq_out}, {31'd0, (m_st & m_en) != 8'd0});
    endtask

    task automatic idle(logic [3:0] rda, string tag);
        step(1'b0, 4'd0, 32'd0, 1'b0, 4'd0, 32'd0, 8'd0, rda, tag);
    endtask

    initial begin
        #(WD_CYC * PERIOD);
        n_bad++;
        $display("FAIL watchdog R10 actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        idle(4'd0, "R10 reset doorbell");
        idle(4'd1, "R10 reset status");
        idle(4'd2, "R10 reset enable");

        // R1: remote set, others unchanged
        step(1'b1, 4'd0, 32'h0000_00A5, 1'b0, 4'd0, 0, 8'd0, 4'd0, "R1 first ring");
        step(1'b1, 4'd0, 32'h0F00_0000, 1'b0, 4'd0, 0, 8'd0, 4'd0, "R1 second ring");
        step(1'b1, 4'd5, 32'hFFFF_FFFF, 1'b0, 4'd0, 0, 8'd0, 4'd0, "R1 off-map remote write");
        // R2: local clear
        step(1'b0, 4'd0, 0, 1'b1, 4'd0, 32'h0000_0005, 8'd0, 4'd0, "R2 partial clear");
        // R5: write-1 to bit 7 ignored while doorbell set
        step(1'b0, 4'd0, 0, 1'b1, 4'd1, 32'h0000_0080, 8'd0, 4'd1, "R5 bit7 clear ignored");
        // R3: collision, set wins
        step(1'b1, 4'd0, 32'h0000_0001, 1'b1, 4'd0, 32'hFFFF_FFFF, 8'd0, 4'd0, "R3 set beats clear");
        // R6: events, bit 7 input ignored, set beats clear
        step(1'b0, 4'd0, 0, 1'b0, 4'd0, 0, 8'h81, 4'd1, "R6 event set");
        step(1'b0, 4'd0, 0, 1'b1, 4'd1, 32'h0000_0001, 8'h01, 4'd1, "R6 event beats clear");
        step(1'b0, 4'd0, 0, 1'b1, 4'd1, 32'h0000_0001, 8'h00, 4'd1, "R6 status clear");
        // R7: enable read/write
        step(1'b0, 4'd0, 0, 1'b1, 4'd2, 32'hFFFF_FF5A, 8'd0, 4'd2, "R7 enable write");
        // R8: enable bit 7, hold, drop by enable, re-enable, service
        step(1'b0, 4'd0, 0, 1'b1, 4'd2, 32'h0000_0080, 8'd0, 4'd1, "R8 enable doorbell irq");
        repeat (3) idle(4'd1, "R8 irq held");
        step(1'b0, 4'd0, 0, 1'b1, 4'd2, 32'h0000_0000, 8'd0, 4'd2, "R8 enable cleared");
        step(1'b0, 4'd0, 0, 1'b1, 4'd2, 32'h0000_0080, 8'd0, 4'd2, "R8 re-enable");
        idle(4'd0, "R8 service read");
        step(1'b0, 4'd0, 0, 1'b1, 4'd0, m_db, 8'd0, 4'd0, "R2 service write-back");
        idle(4'd1, "R5 bit7 follows cleared doorbell");
        // R9: unmapped reads
        idle(4'd3, "R9 unmapped 3");
        idle(4'd15, "R9 unmapped 15");

        // Random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] rd, ld;
            rd = $urandom & $urandom;
            ld = ($urandom % 4 == 0) ? m_db : $urandom;
            step($urandom % 3 == 0, 4'($urandom % 5), rd,
                 $urandom % 2 == 0, 4'($urandom % 4), ld,
                 8'($urandom % 16 == 0 ? $urandom : 0),
                 4'($urandom % 4), "R9 random");
        end

        // R10: reset in the middle of activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_db = '0; m_st = '0; m_en = '0;
        idle(4'd0, "R10 re-reset doorbell");
        idle(4'd1, "R10 re-reset status");
        idle(4'd2, "R10 re-reset enable");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule